// File: doc/BRIEF.md
# Two-Level Global-History Branch Direction Predictor

This block predicts taken or not-taken for the branch being fetched. It keeps a table of 2-bit saturating counters. The table has one group of counters per history value. Each group holds one counter for each PC index. The index is the group of word-address bits of the fetch PC that sit just above the two always-zero byte bits. A short register holds the outcomes of the most recently resolved branches, and its value selects the group. The fetch stage presents its PC word bits and reads the prediction in the same cycle, with no register in the path.

Training happens only when a branch resolves in the execute stage. The execute stage drives the update port with the branch PC word bits and the real outcome. On the next clock edge, the counter chosen by that PC and the current history moves one step toward the outcome. In the same edge, the outcome shifts into the history register.

Each counter is a four-state machine. Its states are SNT (strong not-taken, code 00), WNT (weak not-taken, 01), WT (weak taken, 10) and ST (strong taken, 11). A taken update moves it along SNT→WNT→WT→ST, and a taken update in ST stays in ST. A not-taken update moves it along ST→WT→WNT→SNT, and a not-taken update in SNT stays in SNT.

Top module: `twolvl_predictor`

## Requirements
- R1: The counter used for a PC is entry `{hist, pc_word}` of the table. The history value forms the upper index bits and the PC word bits (byte-address bits IDX_W+1 down to 2) form the lower index bits.
- R2: A taken update advances the selected counter one state toward ST, and it saturates at ST (11).
- R3: A not-taken update moves the selected counter one state toward SNT, and it saturates at SNT (00).
- R4: `pred_taken` is 1 exactly when the counter selected by `fetch_pc` and the current history is WT or ST (upper bit 1). It is valid in the same cycle that `fetch_pc` is presented.
- R5: On each update the history shifts left by one and the outcome enters bit 0 (1 = taken).
- R6: In a cycle without `upd_valid`, no counter and no history bit changes, whatever `upd_pc` and `upd_taken` carry.
- R7: After reset every counter is WNT (01) and the history is 00, so every PC predicts not-taken.
- R8: If an update and a fetch select the same entry in one cycle, the prediction shows the counter value from before the update. The new value is visible from the next cycle.
- R9: Updates made under one history value do not change the counters that another history value selects for the same PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | IDX_W | Fetch PC word bits (byte bits IDX_W+1..2) |
| pred_taken | output | 1 | Combinational prediction, 1 = taken |
| upd_valid | input | 1 | A branch resolved this cycle |
| upd_pc | input | IDX_W | Resolved branch PC word bits |
| upd_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
Almost every fault inside this block shows up as a wrong `pred_taken`, but only when a later fetch reads the damaged entry under the matching history. A counter that wraps instead of saturating, or a history bit that is shifted wrongly, shows at the port one cycle after the faulty update if the fetch that follows reads that entry. A fault that sits in a group the fetch stream never reads stays hidden. The stimulus therefore re-reads the trained entry in every cycle, so that a wrong value appears on `pred_taken` at the next sample.

// File: rtl/twolvl_pkg.sv
package twolvl_pkg;

    // Counter state machine; the upper bit is the taken prediction.
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_state_t;

    localparam ctr_state_t CTR_RESET = CTR_WNT;

endpackage

// File: rtl/twolvl_ctr_step.sv
module twolvl_ctr_step
    import twolvl_pkg::*;
(
    input  ctr_state_t cur,
    input  logic       taken,
    output ctr_state_t nxt
);

    always_comb begin
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = CTR_RESET;
        endcase
    end

endmodule

// File: rtl/twolvl_history.sv
module twolvl_history #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_d;

    generate
        if (HIST_W == 1) begin : g_single
            always_comb hist_d = bit_in;
        end else begin : g_multi
            always_comb hist_d = {hist[HIST_W-2:0], bit_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (shift_en)
            hist <= hist_d;
    end

endmodule

// File: rtl/twolvl_index.sv
module twolvl_index #(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 2,
    localparam int TAB_W = IDX_W + HIST_W
) (
    input  logic [IDX_W-1:0]  pc_word,
    input  logic [HIST_W-1:0] hist,
    output logic [TAB_W-1:0]  idx
);

    // History picks the counter group, PC word bits pick the entry in it.
    always_comb idx = {hist, pc_word};

endmodule

// File: rtl/twolvl_predictor.sv
module twolvl_predictor
    import twolvl_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] fetch_pc,
    output logic             pred_taken,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_pc,
    input  logic             upd_taken
);

    localparam int TAB_W   = IDX_W + HIST_W;
    localparam int ENTRIES = 1 << TAB_W;

    ctr_state_t        table_q [ENTRIES];
    logic [HIST_W-1:0] hist_q;
    logic [TAB_W-1:0]  fetch_idx;
    logic [TAB_W-1:0]  upd_idx;
    ctr_state_t        fetch_cur;
    ctr_state_t        upd_cur;
    ctr_state_t        upd_nxt;

    twolvl_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_fidx (
        .pc_word (fetch_pc),
        .hist    (hist_q),
        .idx     (fetch_idx)
    );

    twolvl_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_uidx (
        .pc_word (upd_pc),
        .hist    (hist_q),
        .idx     (upd_idx)
    );

    always_comb begin
        fetch_cur = table_q[fetch_idx];
        upd_cur   = table_q[upd_idx];
    end

    twolvl_ctr_step u_step (
        .cur   (upd_cur),
        .taken (upd_taken),
        .nxt   (upd_nxt)
    );

    twolvl_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist     (hist_q)
    );

    // State register process for all counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
                table_q[i] <= CTR_RESET;
        end else if (upd_valid) begin
            table_q[upd_idx] <= upd_nxt;
        end
    end

    // Output process: the read is taken before this edge's write.
    always_comb begin
        unique case (fetch_cur)
            CTR_WT, CTR_ST: pred_taken = 1'b1;
            default:        pred_taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/twolvl_predictor_chk.sv
module twolvl_predictor_chk #(
    parameter int IDX_W  = 6,
    parameter int HIST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  fetch_pc,
    input logic              pred_taken,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIST_W-1:0] hist,
    input logic [1:0]        upd_cur,
    input logic [1:0]        upd_nxt
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_sat_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |->
            ((upd_cur != 2'd3 && upd_nxt == upd_cur + 2'd1) ||
             (upd_cur == 2'd3 && upd_nxt == 2'd3)));

    p_sat_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |->
            ((upd_cur != 2'd0 && upd_nxt == upd_cur - 2'd1) ||
             (upd_cur == 2'd0 && upd_nxt == 2'd0)));

    p_hist_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && upd_valid) |=> hist[0] == $past(upd_taken));

    p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !upd_valid) |=> $stable(hist));

    p_idle_pred_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!upd_valid) && $past(fetch_pc) == fetch_pc)
            |-> pred_taken == $past(pred_taken));

    p_reset_nt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!past_ok) |-> !pred_taken);

endmodule

bind twolvl_predictor twolvl_predictor_chk #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_pc   (fetch_pc),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .hist       (hist_q),
    .upd_cur    (upd_cur),
    .upd_nxt    (upd_nxt)
);

// File: tb/sim_twolvl_predictor.sv
module sim_twolvl_predictor;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 6;
    localparam int HIST_W     = 2;
    localparam int ENTRIES    = 1 << (IDX_W + HIST_W);
    localparam int WATCHDOG   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] fetch_pc = '0;
    logic             pred_taken;
    logic             upd_valid = 1'b0;
    logic [IDX_W-1:0] upd_pc = '0;
    logic             upd_taken = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [1:0]        m_tab [ENTRIES];
    logic [HIST_W-1:0] m_hist;

    always #(CLK_PERIOD/2) clk = ~clk;

    twolvl_predictor #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_pc   (fetch_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken)
    );

    typedef struct packed {
        logic             uv;
        logic [IDX_W-1:0] upc;
        logic             ut;
        logic [IDX_W-1:0] fpc;
        logic             exp;
        logic [3:0]       req;
    } vec_t;

    localparam logic [IDX_W-1:0] PA = 6'd16;
    localparam logic [IDX_W-1:0] PB = 6'd17;

    // Rows: update fields, fetch PC, prediction before this row's edge.
    localparam vec_t VECS [14] = '{
        '{1'b0, PA, 1'b0, PA, 1'b0, 4'd7},  // R7 fresh table
        '{1'b1, PA, 1'b1, PA, 1'b0, 4'd8},  // R8 read old 01
        '{1'b0, PA, 1'b0, PA, 1'b0, 4'd9},  // R9 hist 01 set untouched
        '{1'b1, PA, 1'b1, PA, 1'b0, 4'd1},  // R1 entry {01,PA}
        '{1'b1, PA, 1'b0, PA, 1'b0, 4'd5},  // R5 hist now 11
        '{1'b1, PA, 1'b1, PA, 1'b0, 4'd5},  // R5 hist now 10
        '{1'b0, PA, 1'b0, PA, 1'b1, 4'd4},  // R4 {01,PA}=10
        '{1'b1, PA, 1'b1, PA, 1'b1, 4'd8},  // R8 same entry
        '{1'b1, PA, 1'b1, PA, 1'b0, 4'd3},  // R3 {11,PA}=00
        '{1'b1, PA, 1'b1, PA, 1'b0, 4'd2},  // R2 {11,PA}=01
        '{1'b0, PA, 1'b0, PA, 1'b1, 4'd2},  // R2 {11,PA}=10
        '{1'b1, PB, 1'b0, PA, 1'b1, 4'd1},  // R1 other PC trained
        '{1'b0, PB, 1'b1, PA, 1'b1, 4'd6},  // R6 {10,PA}=10
        '{1'b0, PA, 1'b1, PB, 1'b0, 4'd1}   // R1 {10,PB}=01
    };

    function automatic logic model_pred(input logic [IDX_W-1:0] pc);
        return m_tab[{m_hist, pc}][1];
    endfunction

    task automatic model_update(input logic [IDX_W-1:0] pc, input logic t);
        logic [1:0] c;
        c = m_tab[{m_hist, pc}];
        if (t && c != 2'd3)       c = c + 2'd1;
        else if (!t && c != 2'd0) c = c - 2'd1;
        m_tab[{m_hist, pc}] = c;
        m_hist = {m_hist[HIST_W-2:0], t};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < ENTRIES; i++) m_tab[i] = 2'b01;
        m_hist = '0;
        rst_n = 1'b1;
    endtask

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: pred_taken=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Drive at negedge, sample 1 time unit later, model follows the edge.
    task automatic step(input logic uv, input logic [IDX_W-1:0] upc,
                        input logic ut, input logic [IDX_W-1:0] fpc,
                        input string req);
        @(negedge clk);
        upd_valid = uv; upd_pc = upc; upd_taken = ut; fetch_pc = fpc;
        #1;
        check(pred_taken, model_pred(fpc), req);
        @(posedge clk);
        if (uv) model_update(upc, ut);
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: cycles=%0d expected=finish", WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        do_reset();

        // Hand-computed vector walk.
        for (int r = 0; r < 14; r++) begin
            @(negedge clk);
            upd_valid = VECS[r].uv; upd_pc = VECS[r].upc;
            upd_taken = VECS[r].ut; fetch_pc = VECS[r].fpc;
            #1;
            check(pred_taken, VECS[r].exp, $sformatf("R%0d row %0d", VECS[r].req, r));
        end

        // R2: long taken run, wrap would show on the re-read entry.
        do_reset();
        for (int i = 0; i < 8; i++) step(1'b1, PA, 1'b1, PA, "R2 saturate up");
        step(1'b0, PA, 1'b0, PA, "R2 after taken run");

        // R3: long not-taken run.
        for (int i = 0; i < 8; i++) step(1'b1, PA, 1'b0, PA, "R3 saturate down");
        step(1'b0, PA, 1'b0, PA, "R3 after not-taken run");
        step(1'b1, PA, 1'b1, PA, "R3 climb from SNT");
        step(1'b0, PA, 1'b0, PA, "R3 one step up");

        // R6: idle cycles with noisy update fields.
        for (int i = 0; i < 4; i++) step(1'b0, PA, 1'b1, PA, "R6 idle same PC");
        for (int i = 0; i < 4; i++) step(1'b0, PA, i[0], PB, "R6 idle other PC");

        // R9 and R1: alternating outcomes train distinct groups.
        for (int i = 0; i < 12; i++) step(1'b1, PB, i[0], PB, "R9 alternating");
        for (int i = 0; i < 6; i++) step(1'b1, PA, (i % 3) != 0, PB, "R1 cross PC");

        // R7: reset after training clears everything.
        do_reset();
        for (int p = 0; p < 4; p++) step(1'b0, '0, 1'b0, IDX_W'(p * 9), "R7 after reset");

        // R8: same-entry collision under a fresh state.
        step(1'b1, PB, 1'b1, PB, "R8 collision old value");
        step(1'b0, PB, 1'b0, PB, "R8 new hist group");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule